// File: doc/BRIEF.md
# SHA-1 Compression Round Engine

This block applies the SHA-1 compression function to one 512-bit message block. It takes a 160-bit chaining value and returns the updated 160-bit chaining value. Five 32-bit working words are loaded from the chaining value and updated once per clock over 80 steps. The message words come from a 16-word window that slides one word per step and makes each new word from four older ones. After the last step, each working word is added modulo 2^32 to the matching chaining word. The sum is the result.

A controller outside the block does the padding, appends the length and walks through multiple blocks. For each block it presents the block and the chaining value, pulses `start`, waits for `done`, and then feeds `chain_out` back as the next chaining value.

Top module: `sha1_compress`

## Requirements
- R1: While reset is held and on the first cycle after it, `done` and `busy` are 0 and `chain_out` is all zeros.
- R2: A `start` sampled high while `busy` is low loads the inputs. `busy` is high from the next cycle. `done` goes high for exactly one cycle, 81 rising edges after the edge that sampled `start`, and `busy` falls on that same edge.
- R3: While `busy` is high, `start`, `block_in` and `chain_in` are ignored: the pending result and its timing are unchanged.
- R4: `chain_out` is the SHA-1 compression of the sampled block under the sampled chaining value. For the padded one-block message "abc" (`block_in` = 61626380h, then 14 zero words, then 00000018h) under the standard initial value, it is A9993E36 4706816A BA3E2571 7850C26C 9CD0D89D.
- R5: Message words: word 0 is `block_in[511:480]` and word 15 is `block_in[31:0]` (big-endian order). For t ≥ 16, word t is word t-3 XOR word t-8 XOR word t-14 XOR word t-16, rotated left by 1.
- R6: Steps 0–19 use choose (B&C | ~B&D) with constant 5A827999h. Steps 20–39 use parity (B^C^D) with 6ED9EBA1h. Steps 40–59 use majority with 8F1BBCDCh. Steps 60–79 use parity with CA62C1D6h.
- R7: `chain_out` changes only on the edge that raises `done`, and holds its value until the next such edge.
- R8: The chaining value is packed with word H0 in `[159:128]` down to H4 in `[31:0]`, for both input and output. Each output word is the matching input word plus the final working word, modulo 2^32.
- R9: A `start` sampled in the cycle where `done` is high is accepted as a new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin compressing the presented block |
| block_in | input | 512 | Message block, big-endian words |
| chain_in | input | 160 | Incoming chaining value, H0 in the top word |
| busy | output | 1 | A compression is in progress |
| done | output | 1 | One-cycle pulse: `chain_out` is updated |
| chain_out | output | 160 | Updated chaining value |

## Verification
The "abc" block under the standard initial value pins the whole datapath to a published digest. An all-zero block shows whether the constants and the final addition work on their own, because no message bits feed in. All-ones and pseudo-random blocks under nonstandard chaining values test the sliding schedule taps, the function chosen in each step range, and the word order of the chaining addition. A reference model in the bench predicts `busy`, `done` and `chain_out` for every cycle. Its stimulus includes a stray `start` with different data in the middle of a run, which must change nothing, and a restart in the same cycle as `done`.

// File: rtl/sha1_pkg.sv
package sha1_pkg;
   localparam int WORD_W  = 32;
   localparam int N_WORDS = 5;
   localparam int BLK_W   = 512;

   typedef logic [WORD_W-1:0] word_t;

   typedef struct packed {
      word_t a;
      word_t b;
      word_t c;
      word_t d;
      word_t e;
   } state_t;

   function automatic word_t rotl(input word_t x, input int unsigned n);
      word_t r;
      r = x;
      for (int i = 0; i < int'(n); i++) r = {r[WORD_W-2:0], r[WORD_W-1]};
      return r;
   endfunction
endpackage

// File: rtl/sha1_msg_window.sv
module sha1_msg_window
   import sha1_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic              clk,
   input  logic              load,
   input  logic              advance,
   input  logic [BLK_W-1:0]  block_in,
   output word_t             cur_word
);
   localparam int TAP_A = DEPTH - 3;
   localparam int TAP_B = DEPTH - 8;
   localparam int TAP_C = DEPTH - 14;

   if (DEPTH * WORD_W != BLK_W) begin : g_bad_depth
      $error("window depth must cover exactly one block");
   end

   word_t win [DEPTH];
   word_t fresh;

   always_comb fresh = rotl(win[TAP_A] ^ win[TAP_B] ^ win[TAP_C] ^ win[0], 1);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (load)
            win[i] <= block_in[BLK_W-WORD_W*(i+1) +: WORD_W];
         else if (advance) begin
            if (i == DEPTH - 1) win[i] <= fresh;
            else                win[i] <= win[i+1];
         end
      end
   end

   assign cur_word = win[0];
endmodule

// File: rtl/sha1_step_logic.sv
module sha1_step_logic
   import sha1_pkg::*;
#(
   parameter int STEPS     = 80,
   parameter int MAJ_STYLE = 0,
   localparam int STEP_W   = $clog2(STEPS)
) (
   input  state_t            cur,
   input  word_t             w,
   input  logic [STEP_W-1:0] step,
   output state_t            nxt
);
   localparam int SPAN = STEPS / 4;

   word_t f_ch, f_par, f_maj, f_sel, k_sel;

   always_comb begin
      f_ch  = (cur.b & cur.c) | (~cur.b & cur.d);
      f_par = cur.b ^ cur.c ^ cur.d;
   end

   if (MAJ_STYLE == 0) begin : g_maj_sop
      always_comb f_maj = (cur.b & cur.c) | (cur.b & cur.d) | (cur.c & cur.d);
   end else begin : g_maj_fact
      always_comb f_maj = (cur.b & cur.c) | (cur.d & (cur.b | cur.c));
   end

   always_comb begin
      if (int'(step) < SPAN) begin
         f_sel = f_ch;  k_sel = 32'h5A827999;
      end else if (int'(step) < 2*SPAN) begin
         f_sel = f_par; k_sel = 32'h6ED9EBA1;
      end else if (int'(step) < 3*SPAN) begin
         f_sel = f_maj; k_sel = 32'h8F1BBCDC;
      end else begin
         f_sel = f_par; k_sel = 32'hCA62C1D6;
      end
      nxt.a = rotl(cur.a, 5) + f_sel + cur.e + k_sel + w;
      nxt.b = cur.a;
      nxt.c = rotl(cur.b, 30);
      nxt.d = cur.c;
      nxt.e = cur.d;
   end
endmodule

// File: rtl/sha1_chain_add.sv
module sha1_chain_add
   import sha1_pkg::*;
(
   input  state_t prev,
   input  state_t work,
   output state_t sum
);
   localparam int TOT_W = N_WORDS * WORD_W;

   logic [TOT_W-1:0] p_flat, w_flat, s_flat;

   assign p_flat = prev;
   assign w_flat = work;

   for (genvar i = 0; i < N_WORDS; i++) begin : g_word
      assign s_flat[i*WORD_W +: WORD_W] = p_flat[i*WORD_W +: WORD_W] + w_flat[i*WORD_W +: WORD_W];
   end

   assign sum = state_t'(s_flat);
endmodule

// File: rtl/sha1_compress.sv
module sha1_compress
   import sha1_pkg::*;
#(
   parameter int STEPS     = 80,
   parameter int WIN_DEPTH = 16,
   parameter int MAJ_STYLE = 0,
   localparam int STEP_W   = $clog2(STEPS),
   localparam int CHAIN_W  = N_WORDS * WORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [BLK_W-1:0]   block_in,
   input  logic [CHAIN_W-1:0] chain_in,
   output logic               busy,
   output logic               done,
   output logic [CHAIN_W-1:0] chain_out
);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

   if (STEPS != 80 || (STEPS % 4) != 0) begin : g_bad_steps
      $error("step count must be 80 in four equal rounds");
   end
   if (MAJ_STYLE < 0 || MAJ_STYLE > 1) begin : g_bad_maj
      $error("MAJ_STYLE must be 0 or 1");
   end

   typedef enum logic [1:0] {CT_IDLE, CT_RUN, CT_FIN} ctl_t;

   ctl_t              ctl;
   logic [STEP_W-1:0] step;
   state_t            work, nxt, base, total;
   word_t             w_cur;
   logic              accept;

   assign accept = (ctl == CT_IDLE) && start;

   sha1_msg_window #(.DEPTH(WIN_DEPTH)) u_win (
      .clk      (clk),
      .load     (accept),
      .advance  (ctl == CT_RUN),
      .block_in (block_in),
      .cur_word (w_cur)
   );

   sha1_step_logic #(.STEPS(STEPS), .MAJ_STYLE(MAJ_STYLE)) u_step (
      .cur  (work),
      .w    (w_cur),
      .step (step),
      .nxt  (nxt)
   );

   sha1_chain_add u_add (
      .prev (base),
      .work (work),
      .sum  (total)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl       <= CT_IDLE;
         step      <= '0;
         work      <= '0;
         base      <= '0;
         done      <= 1'b0;
         chain_out <= '0;
      end else begin
         done <= 1'b0;
         unique case (ctl)
            CT_IDLE: if (start) begin
               work <= state_t'(chain_in);
               base <= state_t'(chain_in);
               step <= '0;
               ctl  <= CT_RUN;
            end
            CT_RUN: begin
               work <= nxt;
               if (step == LAST_STEP) ctl <= CT_FIN;
               else                   step <= step + 1'b1;
            end
            CT_FIN: begin
               chain_out <= total;
               done      <= 1'b1;
               ctl       <= CT_IDLE;
            end
            default: ctl <= CT_IDLE;
         endcase
      end
   end

   assign busy = (ctl != CT_IDLE);
endmodule

// File: rtl/sha1_compress_chk.sv
module sha1_compress_chk #(
   parameter int STEPS = 80
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         busy,
   input logic         done,
   input logic [159:0] chain_out
);
   localparam int LAT = STEPS + 1;

   logic [7:0] run_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)              run_cnt <= '0;
      else if (start && !busy) run_cnt <= '0;
      else if (busy)           run_cnt <= run_cnt + 1'b1;
   end

   AST_DONE_ONE_CYCLE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
   AST_START_TAKEN:     assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R2
   AST_DONE_LATENCY:    assert property (@(posedge clk) disable iff (!rst_n) done |-> (run_cnt == 8'(LAT))); // R2
   AST_IDLE_ON_DONE:    assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
   AST_OUT_HELD:        assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(chain_out)); // R7
   AST_BUSY_KEEPS_RUN:  assert property (@(posedge clk) disable iff (!rst_n) (busy && run_cnt < 8'(STEPS)) |=> busy); // R3
endmodule

bind sha1_compress sha1_compress_chk #(.STEPS(STEPS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .chain_out (chain_out)
);

// File: tb/sha1_compress_test.sv
module sha1_compress_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [511:0] block_in = '0;
   logic [159:0] chain_in = '0;
   logic         busy, done;
   logic [159:0] chain_out;

   int checks = 0;
   int errors = 0;

   localparam logic [159:0] IV  = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;
   localparam logic [511:0] ABC = {32'h61626380, 448'h0, 32'h00000018};
   localparam logic [159:0] ABC_DIGEST = 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D;

   always #4 clk = ~clk;

   sha1_compress uut (
      .clk(clk), .rst_n(rst_n), .start(start), .block_in(block_in),
      .chain_in(chain_in), .busy(busy), .done(done), .chain_out(chain_out)
   );

   function automatic logic [31:0] rl(input logic [31:0] x, input int n);
      return (x << n) | (x >> (32 - n));
   endfunction

   // behavioural model of the compression (R4, R5, R6, R8)
   function automatic logic [159:0] ref_hash(input logic [511:0] blk, input logic [159:0] h);
      logic [31:0] w [80];
      logic [31:0] a, b, c, d, e, f, k, t;
      for (int i = 0; i < 16; i++) w[i] = blk[511-32*i -: 32];
      for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
      a = h[159:128]; b = h[127:96]; c = h[95:64]; d = h[63:32]; e = h[31:0];
      for (int i = 0; i < 80; i++) begin
         if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
         else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
         else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
         else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
         t = rl(a, 5) + f + e + k + w[i];
         e = d; d = c; c = rl(b, 30); b = a; a = t;
      end
      return {h[159:128] + a, h[127:96] + b, h[95:64] + c, h[63:32] + d, h[31:0] + e};
   endfunction

   // cycle-level model of the handshake (R2, R3, R7, R9)
   logic         m_busy, m_done;
   int           m_cnt;
   logic [159:0] m_res, m_out;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy <= 1'b0; m_done <= 1'b0; m_cnt <= 0; m_res <= '0; m_out <= '0;
      end else begin
         m_done <= 1'b0;
         if (m_busy) begin
            if (m_cnt == 80) begin
               m_busy <= 1'b0; m_done <= 1'b1; m_out <= m_res;
            end else m_cnt <= m_cnt + 1;
         end else if (start) begin
            m_busy <= 1'b1; m_cnt <= 0; m_res <= ref_hash(block_in, chain_in);
         end
      end
   end

   task automatic check(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   bit compare_on = 1'b0;
   always @(negedge clk) if (compare_on && rst_n) begin
      check(busy == m_busy, "R2/R3 busy", 160'(busy), 160'(m_busy));
      check(done == m_done, "R2 done", 160'(done), 160'(m_done));
      check(chain_out == m_out, "R4/R7 chain_out", chain_out, m_out);
   end

   task automatic pulse(input logic [511:0] blk, input logic [159:0] h);
      @(negedge clk);
      block_in = blk; chain_in = h; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done;
      while (!done) @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!done && !busy && chain_out == '0, "R1 during reset", chain_out, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!done && !busy && chain_out == '0, "R1 after reset", chain_out, '0);
      compare_on = 1'b1;

      // R4: published digest
      pulse(ABC, IV);
      wait_done();
      check(chain_out == ABC_DIGEST, "R4 abc digest", chain_out, ABC_DIGEST);

      // R3: stray start with other data mid-run must not disturb
      pulse(ABC, IV);
      repeat (20) @(negedge clk);
      pulse({16{32'hDEADBEEF}}, 160'h0);
      wait_done();
      check(chain_out == ABC_DIGEST, "R3 stray start ignored", chain_out, ABC_DIGEST);

      // R8 / R6: all-zero block, zero chain and custom chain
      pulse(512'h0, 160'h0);
      wait_done();
      pulse(512'h0, 160'h00000001_00000002_00000003_00000004_00000005);
      wait_done();

      // R5: all ones exercises every schedule tap
      pulse({512{1'b1}}, IV);
      wait_done();

      // R9: restart in the done cycle, pseudo-random blocks
      for (int n = 0; n < 4; n++) begin
         logic [511:0] rb;
         logic [159:0] rh;
         for (int j = 0; j < 16; j++) rb[j*32 +: 32] = $urandom;
         for (int j = 0; j < 5; j++)  rh[j*32 +: 32] = $urandom;
         block_in = rb; chain_in = rh; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         wait_done();
         if (n < 3) begin
            start = 1'b1; block_in = ABC; chain_in = IV;
            @(negedge clk);
            start = 1'b0;
            check(busy == 1'b1, "R9 restart on done", 160'(busy), 160'd1);
            wait_done();
            check(chain_out == ABC_DIGEST, "R9 restart result", chain_out, ABC_DIGEST);
         end
      end

      repeat (5) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule